// File: doc/BRIEF.md
# Horizontal Eye Opening Scanner

This block measures how wide the data eye is in the horizontal (time) direction. Two auxiliary sampling phases are positioned inside the eye. The external datapath compares each of them with the centre sampling phase and raises a one-cycle mismatch pulse whenever the two disagree. At each phase position the controller opens a counting window of programmable length and counts the mismatches of each phase. After the window it reports both counts with strobes and decides where to move next.

In automatic mode both phases start at the centre of the 256-step phase range. Phase 0 walks toward position 0 and phase 1 walks toward position 255. Each phase stops at the first position that shows errors, or after it has reported its edge position. When both phases have stopped, the controller publishes the aperture: the distance between the last clean positions on the two sides. In manual mode the two positions come from input ports, and a start runs a single counting window at those positions.

A scan is launched by the rising edge of a start request. A busy flag covers the whole scan, and any request that rises while it is high is thrown away. The aperture output changes only on the cycle the busy flag falls.

Top module: `eyescan_ctrl`

## Requirements
- R1: After reset, `scan_busy` is 0, both position outputs are 128, both strobes are 0 and `aperture` is 0.
- R2: A rising edge on `start_req` while `scan_busy` is 0 sets `scan_busy` on the next clock edge. In automatic mode (`auto_mode`=1, sampled at that edge) both positions load 128.
- R3: A rising edge on `start_req` while `scan_busy` is 1 is discarded. A request still held high when the scan ends does not start a new scan.
- R4: Each position occupies L counting cycles followed by one report cycle, where L = `dwell_len`, or 1 when `dwell_len` is 0. A mismatch pulse is counted only in counting cycles of a phase that is still active. Pulses at any other time are ignored.
- R5: In the report cycle, `cnt0_vld`/`cnt1_vld` are high for one cycle for each phase still active, and `cnt0`/`cnt1` hold that position's count.
- R6: In automatic mode, phase 0 decrements by one and phase 1 increments by one after each report. A phase stops after a report with a nonzero count, or after reporting position 0 (phase 0) or position 255 (phase 1).
- R7: Each count saturates at 2^CW−1 (255 by default) and restarts from 0 at every new position.
- R8: The last clean position of phase 0 is its stop position plus one if that report had errors, and the stop position otherwise. Phase 1 uses minus one in the same case. `aperture` = (clean 1 − clean 0), or 0 if this is negative. It is written only on the edge where `scan_busy` falls.
- R9: `scan_busy` stays high from the accepting edge through the last report cycle and falls on the next edge.
- R10: In manual mode (`auto_mode`=0), the idle position outputs follow `man_pos0`/`man_pos1` with one cycle of latency. A start latches them and runs one window plus one report with both strobes. The scan then ends, and the aperture follows the R8 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Scan request, rising edge is used |
| auto_mode | input | 1 | 1 = internal stepping, 0 = manual positions |
| man_pos0 | input | PW | Manual position of phase 0 |
| man_pos1 | input | PW | Manual position of phase 1 |
| dwell_len | input | TW | Counting cycles per position |
| mis0 | input | 1 | Mismatch pulse of phase 0 |
| mis1 | input | 1 | Mismatch pulse of phase 1 |
| scan_busy | output | 1 | High during a scan |
| pos0 | output | PW | Position of phase 0 |
| pos1 | output | PW | Position of phase 1 |
| cnt0 | output | CW | Error count of phase 0 |
| cnt1 | output | CW | Error count of phase 1 |
| cnt0_vld | output | 1 | Strobe for `cnt0` |
| cnt1_vld | output | 1 | Strobe for `cnt1` |
| aperture | output | PW | Measured eye width in phase steps |

## Verification
An eye model drives mismatches from the current phase positions. Several patterns are used: a narrow off-centre eye, a wide eye with sparse pulses (one every third cycle), an eye closed at the centre, and a fully open eye. These separate the stop-on-first-error rule, counting of isolated pulses, the negative-width clamp with counter saturation, and the edge-of-range stop. Busy lengths show the per-position window and report cycle, including the zero-length window. Extra start pulses during a scan, and a request held across its end, show that requests are dropped. Two manual runs, one straddling the eye and one inside it, show the single-window manual path and the R8 arithmetic on both branches.

// File: rtl/eyescan_pkg.sv
package eyescan_pkg;

  typedef enum logic [1:0] {
    ES_IDLE   = 2'd0,
    ES_DWELL  = 2'd1,
    ES_REPORT = 2'd2
  } es_state_e;

  // Lower clean bound: one step back toward the centre if the position failed.
  function automatic int low_edge(input int pos, input bit failed);
    return failed ? pos + 1 : pos;
  endfunction

  // Upper clean bound plus one, so that it stays non-negative.
  function automatic int high_edge_p1(input int pos, input bit failed);
    return failed ? pos : pos + 1;
  endfunction

  // Width between the clean bounds, clamped at zero.
  function automatic int gap_width(input int lo, input int hi_p1);
    return (hi_p1 > lo) ? hi_p1 - 1 - lo : 0;
  endfunction

endpackage

// File: rtl/eyescan_start_gate.sv
module eyescan_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic busy,
  output logic accept
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_req;
  end

  assign accept = start_req & ~start_q & ~busy;
endmodule

// File: rtl/eyescan_dwell_timer.sv
module eyescan_dwell_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [TW-1:0] len,
  output logic          last
);
  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] eff_len;

  assign eff_len = (len == '0) ? TW'(1) : len;
  assign last    = run && (tcnt_q == eff_len - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       tcnt_q <= '0;
    else if (restart) tcnt_q <= '0;
    else if (run)     tcnt_q <= tcnt_q + TW'(1);
  end
endmodule

// File: rtl/eyescan_err_acc.sv
module eyescan_err_acc #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          hit,
  output logic [CW-1:0] count
);
  logic at_max;

  assign at_max = (count == {CW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (en && hit && !at_max) count <= count + CW'(1);
  end
endmodule

// File: rtl/eyescan_ctrl.sv
module eyescan_ctrl
  import eyescan_pkg::*;
#(
  parameter int PW = 8,
  parameter int CW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          auto_mode,
  input  logic [PW-1:0] man_pos0,
  input  logic [PW-1:0] man_pos1,
  input  logic [TW-1:0] dwell_len,
  input  logic          mis0,
  input  logic          mis1,
  output logic          scan_busy,
  output logic [PW-1:0] pos0,
  output logic [PW-1:0] pos1,
  output logic [CW-1:0] cnt0,
  output logic [CW-1:0] cnt1,
  output logic          cnt0_vld,
  output logic          cnt1_vld,
  output logic [PW-1:0] aperture
);
  localparam int            LW     = PW + 1;
  localparam logic [PW-1:0] CENTER = PW'(1 << (PW - 1));
  localparam logic [PW-1:0] PMAX   = {PW{1'b1}};

  es_state_e     state_q;
  logic          mode_auto_q;
  logic [1:0]    act_q, act_n, stop, hit, acc_en, failed;
  logic [PW-1:0] p0_q, p1_q, p0_n, p1_n;
  logic [LW-1:0] lo_q, hp_q, lo_n, hp_n;
  logic [PW-1:0] ap_q;
  logic [CW-1:0] cnt [2];

  // Named internal events
  logic accept, dwell_last, acc_clr, report_evt, finish_evt;

  assign scan_busy  = (state_q != ES_IDLE);
  assign report_evt = (state_q == ES_REPORT);
  assign acc_clr    = accept | report_evt;
  assign hit        = {mis1, mis0};
  assign acc_en     = (state_q == ES_DWELL) ? act_q : 2'b00;

  eyescan_start_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .busy      (scan_busy),
    .accept    (accept)
  );

  eyescan_dwell_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (acc_clr),
    .run     (state_q == ES_DWELL),
    .len     (dwell_len),
    .last    (dwell_last)
  );

  for (genvar g = 0; g < 2; g++) begin : g_acc
    eyescan_err_acc #(.CW(CW)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (acc_clr),
      .en    (acc_en[g]),
      .hit   (hit[g]),
      .count (cnt[g])
    );
    assign failed[g] = (cnt[g] != '0);
  end

  // Report-cycle decisions
  always_comb begin
    stop[0] = act_q[0] & (~mode_auto_q | failed[0] | (p0_q == '0));
    stop[1] = act_q[1] & (~mode_auto_q | failed[1] | (p1_q == PMAX));
    act_n   = act_q & ~stop;
    lo_n    = stop[0] ? LW'(low_edge(int'(p0_q), failed[0])) : lo_q;
    hp_n    = stop[1] ? LW'(high_edge_p1(int'(p1_q), failed[1])) : hp_q;
    p0_n    = (act_q[0] & ~stop[0]) ? p0_q - PW'(1) : p0_q;
    p1_n    = (act_q[1] & ~stop[1]) ? p1_q + PW'(1) : p1_q;
  end

  assign finish_evt = report_evt && (act_n == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ES_IDLE;
      mode_auto_q <= 1'b1;
      act_q       <= 2'b00;
      p0_q        <= CENTER;
      p1_q        <= CENTER;
      lo_q        <= '0;
      hp_q        <= '0;
      ap_q        <= '0;
    end else begin
      case (state_q)
        ES_IDLE: begin
          if (!auto_mode) begin
            p0_q <= man_pos0;
            p1_q <= man_pos1;
          end
          if (accept) begin
            state_q     <= ES_DWELL;
            mode_auto_q <= auto_mode;
            act_q       <= 2'b11;
            if (auto_mode) begin
              p0_q <= CENTER;
              p1_q <= CENTER;
            end
          end
        end
        ES_DWELL: begin
          if (dwell_last) state_q <= ES_REPORT;
        end
        ES_REPORT: begin
          act_q <= act_n;
          lo_q  <= lo_n;
          hp_q  <= hp_n;
          p0_q  <= p0_n;
          p1_q  <= p1_n;
          if (finish_evt) begin
            state_q <= ES_IDLE;
            ap_q    <= PW'(gap_width(int'(lo_n), int'(hp_n)));
          end else begin
            state_q <= ES_DWELL;
          end
        end
        default: state_q <= ES_IDLE;
      endcase
    end
  end

  assign pos0     = p0_q;
  assign pos1     = p1_q;
  assign cnt0     = cnt[0];
  assign cnt1     = cnt[1];
  assign cnt0_vld = report_evt & act_q[0];
  assign cnt1_vld = report_evt & act_q[1];
  assign aperture = ap_q;
endmodule

// File: rtl/eyescan_ctrl_chk.sv
module eyescan_ctrl_chk #(
  parameter int PW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_mode,
  input logic          busy,
  input logic [PW-1:0] pos0,
  input logic [PW-1:0] pos1,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic          cnt0_vld,
  input logic          cnt1_vld,
  input logic [PW-1:0] aperture,
  input logic          accept,
  input logic          acc_clr,
  input logic          finish_evt,
  input logic          mode_auto
);
  localparam logic [PW-1:0] CENTER = PW'(1 << (PW - 1));
  localparam logic [CW-1:0] CMAX   = {CW{1'b1}};

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_auto_center_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && auto_mode) |=> (pos0 == CENTER && pos1 == CENTER));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish_evt) |=> busy);

  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> !busy);

  assert_ap_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(aperture));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0_vld || cnt1_vld) |=> (!cnt0_vld && !cnt1_vld));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cnt0_vld && !cnt1_vld));

  assert_sat0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == CMAX && !acc_clr) |=> cnt0 == CMAX);

  assert_sat1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt1 == CMAX && !acc_clr) |=> cnt1 == CMAX);

  assert_step0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_auto && !accept) |=>
      (pos0 == $past(pos0) || pos0 == PW'($past(pos0) - PW'(1))));

  assert_step1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_auto && !accept) |=>
      (pos1 == $past(pos1) || pos1 == PW'($past(pos1) + PW'(1))));
endmodule

bind eyescan_ctrl eyescan_ctrl_chk #(.PW(PW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .auto_mode  (auto_mode),
  .busy       (scan_busy),
  .pos0       (pos0),
  .pos1       (pos1),
  .cnt0       (cnt0),
  .cnt1       (cnt1),
  .cnt0_vld   (cnt0_vld),
  .cnt1_vld   (cnt1_vld),
  .aperture   (aperture),
  .accept     (accept),
  .acc_clr    (acc_clr),
  .finish_evt (finish_evt),
  .mode_auto  (mode_auto_q)
);

// File: tb/tb_eyescan_ctrl.sv
module tb_eyescan_ctrl;
  localparam int PW = 8, CW = 8, TW = 16;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0, start_req = 1'b0, auto_mode = 1'b1;
  logic [PW-1:0] man_pos0 = '0, man_pos1 = '0;
  logic [TW-1:0] dwell_len = '0;
  logic          mis0 = 1'b0, mis1 = 1'b0;
  logic          scan_busy, cnt0_vld, cnt1_vld;
  logic [PW-1:0] pos0, pos1, aperture;
  logic [CW-1:0] cnt0, cnt1;

  eyescan_ctrl #(.PW(PW), .CW(CW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .auto_mode(auto_mode),
    .man_pos0(man_pos0), .man_pos1(man_pos1), .dwell_len(dwell_len),
    .mis0(mis0), .mis1(mis1), .scan_busy(scan_busy), .pos0(pos0), .pos1(pos1),
    .cnt0(cnt0), .cnt1(cnt1), .cnt0_vld(cnt0_vld), .cnt1_vld(cnt1_vld),
    .aperture(aperture)
  );

  int checks = 0, errors = 0, cyc = 0;
  int eye_lo = 0, eye_hi = 255, err_mode = 0;
  int last_c0 = 0, last_c1 = 0;

  // Reference model state: phase 0 = idle, 1 = counting, 2 = reporting
  int  m_ph = 0, m_p0 = 128, m_p1 = 128, m_c0 = 0, m_c1 = 0, m_t = 0, m_ap = 0;
  int  m_g0 = 0, m_g1 = 0;
  bit  m_auto = 1, m_on0 = 0, m_on1 = 0, m_prev = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_p0 = 128; m_p1 = 128; m_c0 = 0; m_c1 = 0; m_t = 0; m_ap = 0;
      m_auto = 1; m_on0 = 0; m_on1 = 0; m_prev = 0;
    end else begin
      bit rise;
      int win;
      rise   = start_req && !m_prev;
      m_prev = start_req;
      win    = (dwell_len == 0) ? 1 : int'(dwell_len);
      if (m_ph == 0) begin
        if (!auto_mode) begin m_p0 = man_pos0; m_p1 = man_pos1; end
        if (rise) begin
          m_ph = 1; m_t = 0; m_c0 = 0; m_c1 = 0; m_on0 = 1; m_on1 = 1;
          m_auto = auto_mode;
          if (auto_mode) begin m_p0 = 128; m_p1 = 128; end
        end
      end else if (m_ph == 1) begin
        if (m_on0 && mis0 && m_c0 < 255) m_c0++;
        if (m_on1 && mis1 && m_c1 < 255) m_c1++;
        m_t++;
        if (m_t >= win) m_ph = 2;
      end else begin
        if (m_on0) begin
          if (m_c0 > 0)          begin m_g0 = m_p0 + 1; m_on0 = 0; end
          else if (!m_auto || m_p0 == 0) begin m_g0 = m_p0; m_on0 = 0; end
          else m_p0--;
        end
        if (m_on1) begin
          if (m_c1 > 0)          begin m_g1 = m_p1 - 1; m_on1 = 0; end
          else if (!m_auto || m_p1 == 255) begin m_g1 = m_p1; m_on1 = 0; end
          else m_p1++;
        end
        m_c0 = 0; m_c1 = 0; m_t = 0;
        if (!m_on0 && !m_on1) begin
          m_ph = 0;
          m_ap = (m_g1 > m_g0) ? m_g1 - m_g0 : 0;
        end else m_ph = 1;
      end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog R9 actual=%0d expected<=%0d", cyc, WD_LIMIT);
      finish_run();
    end
    if (rst_n) begin
      cmp("R9 busy", int'(scan_busy), int'(m_ph != 0));
      cmp(m_auto ? "R6 pos0" : "R10 pos0", int'(pos0), m_p0);
      cmp(m_auto ? "R6 pos1" : "R10 pos1", int'(pos1), m_p1);
      cmp("R5 vld0", int'(cnt0_vld), int'(m_ph == 2 && m_on0));
      cmp("R5 vld1", int'(cnt1_vld), int'(m_ph == 2 && m_on1));
      if (m_ph == 2 && m_on0) cmp("R4 cnt0", int'(cnt0), m_c0);
      if (m_ph == 2 && m_on1) cmp("R4 cnt1", int'(cnt1), m_c1);
      cmp("R8 aperture", int'(aperture), m_ap);
      if (cnt0_vld) last_c0 = cnt0;
      if (cnt1_vld) last_c1 = cnt1;
    end
    begin
      bit pat;
      pat  = (err_mode == 0) || (cyc % 3 == 0);
      mis0 = pat && (m_p0 < eye_lo);
      mis1 = pat && (m_p1 > eye_hi);
    end
  endtask

  task automatic run_scan(input int lo, input int hi, input int wl, input int em,
                          output int blen);
    eye_lo = lo; eye_hi = hi; dwell_len = TW'(wl); err_mode = em;
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
    cmp("R2 busy after start", int'(scan_busy), 1);
    if (auto_mode) begin
      cmp("R2 pos0 at centre", int'(pos0), 128);
      cmp("R2 pos1 at centre", int'(pos1), 128);
    end
    blen = 1;
    for (int k = 0; k < 100000; k++) begin
      tick();
      if (!scan_busy) break;
      blen++;
    end
  endtask

  initial begin
    int blen;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    cmp("R1 busy", int'(scan_busy), 0);
    cmp("R1 pos0", int'(pos0), 128);
    cmp("R1 pos1", int'(pos1), 128);
    cmp("R1 strobes", int'(cnt0_vld) + int'(cnt1_vld), 0);
    cmp("R1 aperture", int'(aperture), 0);

    // Narrow off-centre eye, errors on every cycle
    run_scan(100, 150, 3, 0, blen);
    cmp("R4 busy length", blen, 120);
    cmp("R8 aperture narrow eye", int'(aperture), 50);
    repeat (3) tick();

    // Wide eye, sparse error pulses
    run_scan(60, 200, 5, 1, blen);
    cmp("R8 aperture sparse errors", int'(aperture), 140);
    repeat (3) tick();

    // R3: extra requests during the scan and one held across its end
    eye_lo = 100; eye_hi = 150; dwell_len = 16'd4; err_mode = 0;
    start_req = 1'b1; tick(); start_req = 1'b0;
    blen = 1;
    repeat (9) begin tick(); if (scan_busy) blen++; end
    start_req = 1'b1; tick(); if (scan_busy) blen++;
    start_req = 1'b0;
    repeat (8) begin tick(); if (scan_busy) blen++; end
    start_req = 1'b1;
    for (int k = 0; k < 1000; k++) begin
      tick();
      if (!scan_busy) break;
      blen++;
    end
    cmp("R3 busy length unchanged by requests", blen, 150);
    repeat (5) tick();
    cmp("R3 held request not started", int'(scan_busy), 0);
    start_req = 1'b0;
    repeat (2) tick();

    // Closed eye: saturation and negative-width clamp
    run_scan(200, 100, 300, 0, blen);
    cmp("R4 busy length long window", blen, 301);
    cmp("R7 cnt0 saturated", last_c0, 255);
    cmp("R7 cnt1 saturated", last_c1, 255);
    cmp("R8 aperture clamped", int'(aperture), 0);
    repeat (3) tick();

    // Fully open eye, zero window length
    run_scan(0, 255, 0, 0, blen);
    cmp("R4 busy length zero window", blen, 258);
    cmp("R6 pos0 at lower edge", int'(pos0), 0);
    cmp("R6 pos1 at upper edge", int'(pos1), 255);
    cmp("R8 aperture open eye", int'(aperture), 255);
    repeat (3) tick();

    // Manual mode
    auto_mode = 1'b0; man_pos0 = 8'd90; man_pos1 = 8'd160;
    tick(); tick();
    cmp("R10 idle pos0 follows input", int'(pos0), 90);
    cmp("R10 idle pos1 follows input", int'(pos1), 160);
    run_scan(100, 150, 6, 0, blen);
    cmp("R10 busy length single window", blen, 7);
    cmp("R10 aperture straddling eye", int'(aperture), 68);
    repeat (2) tick();
    man_pos0 = 8'd110; man_pos1 = 8'd140;
    tick(); tick();
    run_scan(100, 150, 2, 0, blen);
    cmp("R10 aperture inside eye", int'(aperture), 30);
    repeat (3) tick();

    finish_run();
  end
endmodule